// File: doc/BRIEF.md
# Byte-wide ATM cell bus port (master side)

This block is the ATM-layer end of an 8-bit cell bus toward a PHY device. It has a transmit half and a receive half. The transmit half pulls bytes from a local buffer through a valid/ready stream. It frames them into 53-byte cells and drives the data, start-of-cell, enable and parity pins. It respects the PHY's transmit flow-control flag. The receive half drives the receive enable and samples the data and start-of-cell pins. It hunts for a start-of-cell and writes the bytes of each cell into a local buffer by index. After the 53rd byte it raises a cell-done strobe. A start-of-cell that arrives mid-cell abandons the partial cell and bumps an error counter.

Both halves run on one clock, the PHY clock input. The block forwards that clock as the transmit and receive bus clocks. The `cell_mode` input selects how the two PHY flags are read. At 0 (octet mode) each flag gives per-byte readiness. At 1 (cell mode) each flag announces a whole cell. Pin enables and start-of-cell are active-low. The stream side is active-high.

Stream rules. The transmit source holds `s_tx_data` stable while `s_tx_valid` is high and `s_tx_ready` is low. A byte moves on a clock edge where both are high. Back-pressure comes from `s_tx_ready`, which follows the PHY flag. The receive buffer applies back-pressure through `rx_room`. While it is low, no new cell is started, but a cell already in progress is always completed. The buffer must treat indexed writes as tentative until `rx_cell_done`.

Top module: `utl_l1_port`

## Requirements
- R1: `tx_bus_clk` and `rx_bus_clk` are the `clk` input passed through with no logic state; each equals `clk` at all times.
- R2: Every transmit byte appears on `utx_data` with `utx_enb_n` low in the cycle after its stream handshake. Bytes are grouped in cells of 53. `utx_soc_n` is low only with byte 0 of each cell, counted from reset.
- R3: With the default `ODD_PARITY=1`, `utx_par` makes the number of ones across `utx_data` and `utx_par` odd whenever `utx_enb_n` is low. With `ODD_PARITY=0` that number is even.
- R4: In octet mode (`cell_mode`=0), `s_tx_ready` equals `utx_room` (high = PHY can take a byte), and a byte is sent for every handshake.
- R5: In cell mode (`cell_mode`=1), a cell starts only on a handshake in a cycle where `utx_room` is high. After byte 0, `s_tx_ready` stays high regardless of `utx_room` until byte 52 has been taken.
- R6: `urx_enb_n` is a register output. After an edge it is low if a cell is in progress, or if `rx_room` is high and either octet mode is selected or `urx_avail` is high. Otherwise it is high.
- R7: A receive byte is captured on an edge where `urx_enb_n` was low during the preceding cycle, and in octet mode `urx_avail` was also high. Nothing is written on any other edge.
- R8: Outside a cell, captured bytes with `urx_soc_n` high are dropped. A captured byte with `urx_soc_n` low starts a cell and is written with index 0.
- R9: Each captured in-cell byte is written once on the cycle after capture (`rx_wr_valid`, index 0..52, data). `rx_cell_done` pulses together with the write of index 52 and at no other time.
- R10: A start-of-cell captured while a cell is in progress discards that cell with no done strobe. It adds one to `rx_err_cnt`, which saturates at all-ones. The new byte is written as index 0.
- R11: During reset `utx_enb_n`, `utx_soc_n` and `urx_enb_n` are high, `rx_wr_valid` and `rx_cell_done` are low, and `rx_err_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock, sole clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_mode | input | 1 | 0: flags per byte, 1: flags per cell |
| tx_bus_clk | output | 1 | Forwarded transmit bus clock |
| rx_bus_clk | output | 1 | Forwarded receive bus clock |
| s_tx_valid | input | 1 | Transmit stream byte valid |
| s_tx_ready | output | 1 | Transmit stream ready |
| s_tx_data | input | DATA_W | Transmit stream byte |
| utx_data | output | DATA_W | Transmit bus data |
| utx_soc_n | output | 1 | Transmit start-of-cell, active-low |
| utx_enb_n | output | 1 | Transmit enable, active-low |
| utx_par | output | 1 | Transmit data parity |
| utx_room | input | 1 | PHY transmit flag: not full / cell available |
| urx_data | input | DATA_W | Receive bus data |
| urx_soc_n | input | 1 | Receive start-of-cell, active-low |
| urx_avail | input | 1 | PHY receive flag: not empty / cell available |
| urx_enb_n | output | 1 | Receive enable, active-low |
| rx_room | input | 1 | Receive buffer can accept a new cell |
| rx_wr_valid | output | 1 | Receive byte write strobe |
| rx_wr_idx | output | IDX_W | Byte index within the cell |
| rx_wr_data | output | DATA_W | Receive byte |
| rx_cell_done | output | 1 | Complete cell committed |
| rx_err_cnt | output | ERR_W | Saturating count of cut-short cells |

## Verification
Transmit runs first in octet mode against a PHY flag that drops every few cycles and a source that stalls periodically. This separates per-byte flow control from cell framing. It then runs in cell mode with long flag-off windows, which shows whether a started cell ignores the flag and a new one waits for it. The receive stream is the same script in both modes. The script holds full cells, idle bytes outside a cell, a 20-byte fragment and a 52-byte fragment each followed by a new start-of-cell. It tells alignment, exact-length commit and error counting apart. Gaps in buffer room and in the PHY's availability flag test that enables and capture qualify correctly.

// File: rtl/utl_pkg.sv
package utl_pkg;
  typedef enum logic {
    RX_HUNT    = 1'b0,
    RX_IN_CELL = 1'b1
  } rx_state_e;
endpackage

// File: rtl/utl_clk_fwd.sv
module utl_clk_fwd #(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  output logic [N_OUT-1:0] bus_clk
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_fwd
    assign bus_clk[g] = clk;
  end
endmodule

// File: rtl/utl_sat_cnt.sv
module utl_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/utl_tx_path.sv
module utl_tx_path #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_mode,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              room,
  output logic [DATA_W-1:0] pin_data,
  output logic              pin_soc_n,
  output logic              pin_enb_n,
  output logic              pin_par
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] pos_q;
  logic             mid_cell;
  logic             fire;
  logic             par_d;

  assign mid_cell = (pos_q != '0);
  assign s_ready  = cell_mode ? (mid_cell | room) : room;
  assign fire     = s_valid & s_ready;

  if (ODD_PARITY) begin : g_odd
    assign par_d = ~(^s_data);
  end else begin : g_even
    assign par_d = ^s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      pin_data  <= '0;
      pin_par   <= ODD_PARITY;
      pin_soc_n <= 1'b1;
      pin_enb_n <= 1'b1;
    end else if (fire) begin
      pin_data  <= s_data;
      pin_par   <= par_d;
      pin_enb_n <= 1'b0;
      pin_soc_n <= mid_cell;
      pos_q     <= (pos_q == LAST) ? '0 : pos_q + IDX_W'(1);
    end else begin
      pin_enb_n <= 1'b1;
      pin_soc_n <= 1'b1;
    end
  end
endmodule

// File: rtl/utl_rx_path.sv
module utl_rx_path
  import utl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cell_mode,
  input  logic [DATA_W-1:0]            pin_data,
  input  logic                         pin_soc_n,
  input  logic                         pin_avail,
  input  logic                         room,
  output logic                         pin_enb_n,
  output logic                         wr_valid,
  output logic [$clog2(CELL_BYTES)-1:0] wr_idx,
  output logic [DATA_W-1:0]            wr_data,
  output logic                         cell_done,
  output logic                         err_inc
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  rx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, widx_d;
  logic             en_q, en_d;
  logic             take, wr_d, done_d;

  assign take      = en_q & (cell_mode | pin_avail);
  assign pin_enb_n = ~en_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    widx_d  = idx_q;
    wr_d    = 1'b0;
    done_d  = 1'b0;
    err_inc = 1'b0;
    if (take) begin
      if (!pin_soc_n) begin
        err_inc = (state_q == RX_IN_CELL);
        wr_d    = 1'b1;
        widx_d  = '0;
        state_d = RX_IN_CELL;
        idx_d   = IDX_W'(1);
      end else if (state_q == RX_IN_CELL) begin
        wr_d = 1'b1;
        if (idx_q == LAST) begin
          done_d  = 1'b1;
          state_d = RX_HUNT;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
    en_d = (state_d == RX_IN_CELL) | (room & (~cell_mode | pin_avail));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_HUNT;
      idx_q     <= '0;
      en_q      <= 1'b0;
      wr_valid  <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      cell_done <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      en_q      <= en_d;
      wr_valid  <= wr_d;
      cell_done <= done_d;
      if (wr_d) begin
        wr_idx  <= widx_d;
        wr_data <= pin_data;
      end
    end
  end
endmodule

// File: rtl/utl_l1_port.sv
module utl_l1_port #(
  parameter int  DATA_W     = 8,
  parameter int  CELL_BYTES = 53,
  parameter int  ERR_W      = 8,
  parameter bit  ODD_PARITY = 1'b1,
  localparam int IDX_W      = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_mode,
  output logic              tx_bus_clk,
  output logic              rx_bus_clk,
  input  logic              s_tx_valid,
  output logic              s_tx_ready,
  input  logic [DATA_W-1:0] s_tx_data,
  output logic [DATA_W-1:0] utx_data,
  output logic              utx_soc_n,
  output logic              utx_enb_n,
  output logic              utx_par,
  input  logic              utx_room,
  input  logic [DATA_W-1:0] urx_data,
  input  logic              urx_soc_n,
  input  logic              urx_avail,
  output logic              urx_enb_n,
  input  logic              rx_room,
  output logic              rx_wr_valid,
  output logic [IDX_W-1:0]  rx_wr_idx,
  output logic [DATA_W-1:0] rx_wr_data,
  output logic              rx_cell_done,
  output logic [ERR_W-1:0]  rx_err_cnt
);
  logic [1:0] fwd_clks;
  logic       err_inc;

  utl_clk_fwd #(.N_OUT(2)) u_clk (
    .clk     (clk),
    .bus_clk (fwd_clks)
  );
  assign tx_bus_clk = fwd_clks[0];
  assign rx_bus_clk = fwd_clks[1];

  utl_tx_path #(
    .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .ODD_PARITY(ODD_PARITY)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_mode (cell_mode),
    .s_valid   (s_tx_valid),
    .s_ready   (s_tx_ready),
    .s_data    (s_tx_data),
    .room      (utx_room),
    .pin_data  (utx_data),
    .pin_soc_n (utx_soc_n),
    .pin_enb_n (utx_enb_n),
    .pin_par   (utx_par)
  );

  utl_rx_path #(
    .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_mode (cell_mode),
    .pin_data  (urx_data),
    .pin_soc_n (urx_soc_n),
    .pin_avail (urx_avail),
    .room      (rx_room),
    .pin_enb_n (urx_enb_n),
    .wr_valid  (rx_wr_valid),
    .wr_idx    (rx_wr_idx),
    .wr_data   (rx_wr_data),
    .cell_done (rx_cell_done),
    .err_inc   (err_inc)
  );

  utl_sat_cnt #(.W(ERR_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_inc),
    .cnt   (rx_err_cnt)
  );
endmodule

// File: rtl/utl_port_chk.sv
module utl_port_chk #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int ERR_W      = 8,
  parameter bit ODD_PARITY = 1'b1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cell_mode,
  input logic                          utx_room,
  input logic [DATA_W-1:0]             utx_data,
  input logic                          utx_soc_n,
  input logic                          utx_enb_n,
  input logic                          utx_par,
  input logic                          urx_enb_n,
  input logic                          rx_wr_valid,
  input logic [$clog2(CELL_BYTES)-1:0] rx_wr_idx,
  input logic                          rx_cell_done,
  input logic [ERR_W-1:0]              rx_err_cnt
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (!utx_enb_n) seen_q <= (seen_q == LAST) ? '0 : seen_q + IDX_W'(1);
  end

  AST_SOC_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    !utx_enb_n |-> ((!utx_soc_n) == (seen_q == '0))); // R2

  AST_SOC_NEEDS_ENB: assert property (@(posedge clk) disable iff (!rst_n)
    !utx_soc_n |-> !utx_enb_n); // R2

  AST_TX_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    !utx_enb_n |-> ((^{utx_data, utx_par}) == ODD_PARITY)); // R3

  AST_OCTET_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cell_mode && !utx_room) |=> utx_enb_n); // R4

  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    urx_enb_n |=> !rx_wr_valid); // R7

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cell_done |-> (rx_wr_valid && rx_wr_idx == LAST)); // R9

  AST_ERR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_err_cnt >= $past(rx_err_cnt))); // R10
endmodule

bind utl_l1_port utl_port_chk #(
  .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .ERR_W(ERR_W), .ODD_PARITY(ODD_PARITY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cell_mode    (cell_mode),
  .utx_room     (utx_room),
  .utx_data     (utx_data),
  .utx_soc_n    (utx_soc_n),
  .utx_enb_n    (utx_enb_n),
  .utx_par      (utx_par),
  .urx_enb_n    (urx_enb_n),
  .rx_wr_valid  (rx_wr_valid),
  .rx_wr_idx    (rx_wr_idx),
  .rx_cell_done (rx_cell_done),
  .rx_err_cnt   (rx_err_cnt)
);

// File: tb/sim_utl_l1_port.sv
module sim_utl_l1_port;
  localparam int CB = 53;

  logic       clk = 1'b0;
  logic       rst_n, cell_mode, tx_bus_clk, rx_bus_clk;
  logic       s_tx_valid, s_tx_ready;
  logic [7:0] s_tx_data, utx_data, urx_data, rx_wr_data, rx_err_cnt;
  logic       utx_soc_n, utx_enb_n, utx_par, utx_room;
  logic       urx_soc_n, urx_avail, urx_enb_n, rx_room;
  logic       rx_wr_valid, rx_cell_done;
  logic [5:0] rx_wr_idx;

  always #5 clk = ~clk;

  utl_l1_port u0 (
    .clk(clk), .rst_n(rst_n), .cell_mode(cell_mode),
    .tx_bus_clk(tx_bus_clk), .rx_bus_clk(rx_bus_clk),
    .s_tx_valid(s_tx_valid), .s_tx_ready(s_tx_ready), .s_tx_data(s_tx_data),
    .utx_data(utx_data), .utx_soc_n(utx_soc_n), .utx_enb_n(utx_enb_n),
    .utx_par(utx_par), .utx_room(utx_room),
    .urx_data(urx_data), .urx_soc_n(urx_soc_n), .urx_avail(urx_avail),
    .urx_enb_n(urx_enb_n), .rx_room(rx_room),
    .rx_wr_valid(rx_wr_valid), .rx_wr_idx(rx_wr_idx), .rx_wr_data(rx_wr_data),
    .rx_cell_done(rx_cell_done), .rx_err_cnt(rx_err_cnt)
  );

  int errors = 0, checks = 0;
  // reference model state
  int tcnt = 0, txn = 0, e_enb = 1, e_soc = 1, e_dat = 0;
  int men = 0, in_cell = 0, ridx = 0, rerr = 0, m_cap = 0;
  int e_wv = 0, e_done = 0, e_idx = 0, e_wd = 0;
  int done_seen = 0;
  int q_soc[$], q_dat[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tx_byte(input int n);
    return (n * 29 + 3) & 255;
  endfunction

  task automatic push_cell(input int len, input int tag);
    for (int i = 0; i < len; i++) begin
      q_soc.push_back(i == 0);
      q_dat.push_back((tag * 16 + i) & 255);
    end
  endtask

  task automatic push_script();
    push_cell(CB, 1);
    for (int i = 0; i < 3; i++) begin q_soc.push_back(0); q_dat.push_back(200 + i); end
    push_cell(20, 2);
    push_cell(CB, 3);
    push_cell(CB - 1, 4);
    push_cell(CB, 5);
    push_cell(CB, 6);
  endtask

  function automatic int ready_model();
    if (cell_mode) return (tcnt != 0 || utx_room) ? 1 : 0;
    return utx_room ? 1 : 0;
  endfunction

  task automatic drive(input int n, input int ph);
    if (m_cap != 0 && q_soc.size() > 0) begin
      void'(q_soc.pop_front());
      void'(q_dat.pop_front());
    end
    m_cap = 0;
    s_tx_valid = (n % 11 != 4);
    s_tx_data  = 8'(tx_byte(txn));
    utx_room   = (ph == 0) ? (n % 6 != 2) : (((n / 70) % 2 == 0) || (n % 9 == 0));
    rx_room    = !((n % 23 == 7) || (n % 23 == 8));
    if (q_soc.size() > 0) begin
      urx_data  = 8'(q_dat[0]);
      urx_soc_n = !q_soc[0][0];
      urx_avail = (ph == 1) || (n % 4 != 1);
    end else begin
      urx_data  = 8'hA5;
      urx_soc_n = 1'b1;
      urx_avail = 1'b0;
    end
  endtask

  task automatic model_step();
    int fire, cap, nonempty;
    fire = s_tx_valid && ready_model();
    if (fire != 0) begin
      e_enb = 0; e_soc = (tcnt != 0); e_dat = s_tx_data;
      tcnt = (tcnt == CB - 1) ? 0 : tcnt + 1;
      txn++;
    end else begin
      e_enb = 1; e_soc = 1;
    end
    nonempty = (q_soc.size() > 0);
    cap = men && (cell_mode || urx_avail);
    e_wv = 0; e_done = 0;
    if (cap != 0) begin
      if (!urx_soc_n) begin
        if (in_cell != 0 && rerr < 255) rerr++;
        e_wv = 1; e_idx = 0; e_wd = urx_data; in_cell = 1; ridx = 1;
      end else if (in_cell != 0) begin
        e_wv = 1; e_idx = ridx; e_wd = urx_data;
        if (ridx == CB - 1) begin e_done = 1; in_cell = 0; ridx = 0; end
        else ridx++;
      end
    end
    m_cap = cap && nonempty;
    men = in_cell || (rx_room && (!cell_mode || urx_avail));
  endtask

  task automatic compare(input int ph);
    string fl;
    fl = (ph == 0) ? "R4" : "R5";
    chk({fl, " tx enable"}, utx_enb_n, e_enb);
    if (!utx_enb_n) begin
      chk("R2 tx start-of-cell", utx_soc_n, e_soc);
      chk("R2 tx data", utx_data, e_dat);
      chk("R3 odd parity", $countones({utx_data, utx_par}) % 2, 1);
    end
    chk("R6 rx enable", urx_enb_n, !men);
    chk("R7 rx write strobe", rx_wr_valid, e_wv);
    if (e_wv != 0) begin
      chk("R8 rx index", rx_wr_idx, e_idx);
      chk("R9 rx data", rx_wr_data, e_wd);
    end
    chk("R9 cell done", rx_cell_done, e_done);
    chk("R10 error count", rx_err_cnt, rerr);
    if (rx_cell_done) done_seen++;
  endtask

  initial begin
    #(100000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cell_mode = 0; s_tx_valid = 0; s_tx_data = 0; utx_room = 0;
    urx_data = 0; urx_soc_n = 1; urx_avail = 0; rx_room = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tx enable idle", utx_enb_n, 1);
    chk("R11 tx soc idle", utx_soc_n, 1);
    chk("R11 rx enable idle", urx_enb_n, 1);
    chk("R11 no write", rx_wr_valid, 0);
    chk("R11 no done", rx_cell_done, 0);
    chk("R11 error count zero", rx_err_cnt, 0);
    // R1 forwarded clocks, low phase
    chk("R1 tx clock low", tx_bus_clk, clk);
    chk("R1 rx clock low", rx_bus_clk, clk);
    rst_n = 1;
    for (int ph = 0; ph < 2; ph++) begin
      cell_mode = ph[0];
      push_script();
      for (int n = 0; n < 900; n++) begin
        drive(n, ph);
        #1;
        chk(ph == 0 ? "R4 stream ready" : "R5 stream ready", s_tx_ready, ready_model());
        @(posedge clk);
        model_step();
        if (n == 5) begin
          #1;
          chk("R1 tx clock high", tx_bus_clk, 1);
          chk("R1 rx clock high", rx_bus_clk, 1);
        end
        @(negedge clk);
        compare(ph);
      end
    end
    chk("R9 complete cells committed", done_seen, 8);
    chk("R10 cut-short cells counted", rx_err_cnt, 4);
    chk("R8 receive script consumed", q_soc.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule